// File: doc/BRIEF.md
# Temperature-Derated Refresh Scheduler

This block sits beside the command arbiter of a DRAM controller and decides when a refresh must be issued to an eight-bank device. It asks for the device's die-temperature status at a fixed period. The answer comes back as a 2-bit derate code, and the block shortens its refresh interval to match that code: nominal, half or quarter length. The fourth code value marks an over-temperature condition. That code keeps the quarter interval and also raises an alarm output.

Two refresh styles are available. In all-bank mode each request covers the whole device, and the request waits until no bank is busy. In per-bank mode the interval is an eighth as long. Each request names one bank, and the banks are taken in strict rotation. A request waits only while its own target bank is busy, so traffic to the other seven banks can carry on. Elapsed intervals that have not yet been served are counted, up to a limit. When the count reaches that limit the request is flagged urgent and ignores the busy indications. The arbiter retires one refresh in each cycle in which it grants a raised request.

Top module: `temp_refresh_sched`

## Requirements
- R1: While reset is asserted and right after it, refReq, refUrgent, pollReq and overTempAlarm are low, refBank is 0 and refAllBank is high, so the block starts in all-bank mode at nominal rate.
- R2: pollReq is high for exactly one cycle in every POLL_PERIOD cycles.
- R3: pollCode is captured only in a cycle with pollValid high. Code 0 selects the nominal rate, code 1 double rate, and codes 2 and 3 quadruple rate.
- R4: The interval is BASE_INTERVAL cycles in all-bank mode and BASE_INTERVAL/NUM_BANKS cycles in per-bank mode, divided by 1, 2 or 4 according to the rate.
- R5: A new code or mode does not change the interval in progress. It applies from the next interval reload, and the refresh that this reload releases already uses the new mode.
- R6: overTempAlarm rises in the cycle after code 3 is captured and falls in the cycle after any other code is captured.
- R7: Each elapsed interval adds one pending refresh. refReq stays high while refreshes are pending and allowed. Each cycle with refReq and refGrant both high retires one.
- R8: In per-bank mode refAllBank is low, and refBank steps by one on each grant in the order 0,1,...,7 and then wraps to 0.
- R9: In per-bank mode a non-urgent request is withheld while the target bank's bankBusy bit is set. Busy bits of the other banks have no effect.
- R10: In all-bank mode refAllBank is high, a non-urgent request is withheld while any bankBusy bit is set, and grants leave refBank unchanged.
- R11: The pending count saturates at MAX_POSTPONE. refUrgent is high exactly when the count is at that limit, and an urgent request is raised regardless of bankBusy.
- R12: With no refresh pending, refReq and refUrgent are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| perBankMode | input | 1 | 1 selects per-bank refresh, 0 selects all-bank refresh |
| pollReq | output | 1 | One-cycle request to read the temperature status |
| pollValid | input | 1 | pollCode carries a fresh status |
| pollCode | input | 2 | Derate code: 0 nominal, 1 double, 2 quadruple, 3 over-temperature |
| overTempAlarm | output | 1 | The last captured code was 3 |
| bankBusy | input | NUM_BANKS | Per-bank activity from the command side |
| refReq | output | 1 | Refresh request to the arbiter |
| refGrant | input | 1 | Arbiter accepts the request this cycle |
| refAllBank | output | 1 | Request covers all banks |
| refBank | output | BANK_W | Target bank of a per-bank request |
| refUrgent | output | 1 | Pending limit reached; request must be served |

## Verification
The interval is measured as the spacing of single-cycle grants under every derate code in both modes. A code is changed in the middle of an interval, so that the old length must appear once before the new one. Separate stimuli show that a code presented without pollValid leaves the spacing unchanged, and that code 3 both raises the alarm and gives quarter spacing. Busy patterns check three cases: blocking only the target bank, blocking every bank except the target, and blocking one bank in all-bank mode. These show which busy bits matter in each mode, and that only the urgent path gets past a block. Withholding the grant for longer than the postpone limit checks that the count saturates, by counting exactly MAX_POSTPONE back-to-back grants once the grant returns.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  // Strobes the control half hands to the datapath each cycle
  typedef struct packed {
    logic retire;   // one pending refresh served
    logic advance;  // step the per-bank rotation pointer
  } schedStrobes_t;

  // Derate code to right-shift of the nominal interval
  function automatic logic [1:0] rateShift(input logic [1:0] code);
    case (code)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/refsched_datapath.sv
module refsched_datapath
  import refsched_pkg::*;
#(
  parameter int NUM_BANKS     = 8,
  parameter int BASE_INTERVAL = 3120,
  parameter int POLL_PERIOD   = 1024,
  parameter int MAX_POSTPONE  = 8,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int PEND_W = $clog2(MAX_POSTPONE + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              perBankMode,
  input  logic              pollValid,
  input  logic [1:0]        pollCode,
  input  schedStrobes_t     strobes,
  output logic              pollReq,
  output logic              overTempAlarm,
  output logic              perBankActive,
  output logic [PEND_W-1:0] pendingCnt,
  output logic [BANK_W-1:0] bankPtr
);

  localparam int PB_INTERVAL = BASE_INTERVAL / NUM_BANKS;
  localparam int CNT_W       = $clog2(BASE_INTERVAL + 1);
  localparam int POLL_W      = $clog2(POLL_PERIOD);

  logic [POLL_W-1:0] pollCnt;
  logic [1:0]        polledCode;
  logic [CNT_W-1:0]  intervalCnt;
  logic [CNT_W-1:0]  baseLen;
  logic [CNT_W-1:0]  nextLen;
  logic              tick;

  // Status poll timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pollCnt <= '0;
    end else if (pollCnt == POLL_W'(POLL_PERIOD - 1)) begin
      pollCnt <= '0;
    end else begin
      pollCnt <= pollCnt + POLL_W'(1);
    end
  end
  assign pollReq = (pollCnt == POLL_W'(POLL_PERIOD - 1));

  // Latest returned derate code
  always_ff @(posedge clk) begin
    if (!rstN) begin
      polledCode <= 2'd0;
    end else if (pollValid) begin
      polledCode <= pollCode;
    end
  end
  assign overTempAlarm = (polledCode == 2'd3);

  // Reload value from the mode and code seen at reload time
  always_comb begin
    baseLen = perBankMode ? CNT_W'(PB_INTERVAL) : CNT_W'(BASE_INTERVAL);
    nextLen = baseLen >> rateShift(polledCode);
  end

  assign tick = (intervalCnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intervalCnt   <= CNT_W'(BASE_INTERVAL);
      perBankActive <= 1'b0;
    end else if (tick) begin
      intervalCnt   <= nextLen;
      perBankActive <= perBankMode;
    end else begin
      intervalCnt   <= intervalCnt - CNT_W'(1);
    end
  end

  // Postponed refresh count, saturating at the limit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingCnt <= '0;
    end else begin
      case ({tick, strobes.retire})
        2'b10: if (pendingCnt != PEND_W'(MAX_POSTPONE)) pendingCnt <= pendingCnt + PEND_W'(1);
        2'b01: pendingCnt <= pendingCnt - PEND_W'(1);
        default: pendingCnt <= pendingCnt;
      endcase
    end
  end

  // Round-robin bank pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankPtr <= '0;
    end else if (strobes.advance) begin
      bankPtr <= (bankPtr == BANK_W'(NUM_BANKS - 1)) ? '0 : bankPtr + BANK_W'(1);
    end
  end

endmodule

// File: rtl/refsched_control.sv
module refsched_control
  import refsched_pkg::*;
#(
  parameter int NUM_BANKS    = 8,
  parameter int MAX_POSTPONE = 8,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int PEND_W = $clog2(MAX_POSTPONE + 1)
) (
  input  logic [PEND_W-1:0]    pendingCnt,
  input  logic [BANK_W-1:0]    bankPtr,
  input  logic                 perBankActive,
  input  logic [NUM_BANKS-1:0] bankBusy,
  input  logic                 refGrant,
  output logic                 refReq,
  output logic                 refUrgent,
  output schedStrobes_t        strobes
);

  logic atLimit;
  logic targetBusy;

  always_comb begin
    atLimit    = (pendingCnt == PEND_W'(MAX_POSTPONE));
    targetBusy = perBankActive ? bankBusy[bankPtr] : (|bankBusy);
    refUrgent  = atLimit;
    refReq     = (pendingCnt != '0) && (!targetBusy || atLimit);
    strobes.retire  = refReq && refGrant;
    strobes.advance = refReq && refGrant && perBankActive;
  end

endmodule

// File: rtl/temp_refresh_sched.sv
module temp_refresh_sched
  import refsched_pkg::*;
#(
  parameter int NUM_BANKS     = 8,
  parameter int BASE_INTERVAL = 3120,
  parameter int POLL_PERIOD   = 1024,
  parameter int MAX_POSTPONE  = 8,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int PEND_W = $clog2(MAX_POSTPONE + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 perBankMode,
  output logic                 pollReq,
  input  logic                 pollValid,
  input  logic [1:0]           pollCode,
  output logic                 overTempAlarm,
  input  logic [NUM_BANKS-1:0] bankBusy,
  output logic                 refReq,
  input  logic                 refGrant,
  output logic                 refAllBank,
  output logic [BANK_W-1:0]    refBank,
  output logic                 refUrgent
);

  schedStrobes_t     strobes;
  logic              perBankActive;
  logic [PEND_W-1:0] pendingCnt;
  logic [BANK_W-1:0] bankPtr;

  refsched_datapath #(
    .NUM_BANKS(NUM_BANKS), .BASE_INTERVAL(BASE_INTERVAL),
    .POLL_PERIOD(POLL_PERIOD), .MAX_POSTPONE(MAX_POSTPONE)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .perBankMode(perBankMode),
    .pollValid(pollValid), .pollCode(pollCode), .strobes(strobes),
    .pollReq(pollReq), .overTempAlarm(overTempAlarm),
    .perBankActive(perBankActive), .pendingCnt(pendingCnt), .bankPtr(bankPtr)
  );

  refsched_control #(
    .NUM_BANKS(NUM_BANKS), .MAX_POSTPONE(MAX_POSTPONE)
  ) control_i (
    .pendingCnt(pendingCnt), .bankPtr(bankPtr), .perBankActive(perBankActive),
    .bankBusy(bankBusy), .refGrant(refGrant),
    .refReq(refReq), .refUrgent(refUrgent), .strobes(strobes)
  );

  assign refAllBank = !perBankActive;
  assign refBank    = bankPtr;

endmodule

// File: rtl/temp_refresh_sched_chk.sv
module temp_refresh_sched_chk #(
  parameter int NUM_BANKS    = 8,
  parameter int MAX_POSTPONE = 8,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int PEND_W = $clog2(MAX_POSTPONE + 1)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 pollReq,
  input logic                 pollValid,
  input logic [1:0]           pollCode,
  input logic                 overTempAlarm,
  input logic [NUM_BANKS-1:0] bankBusy,
  input logic                 refReq,
  input logic                 refGrant,
  input logic                 refAllBank,
  input logic [BANK_W-1:0]    refBank,
  input logic                 refUrgent,
  input logic [PEND_W-1:0]    pendingCnt
);

  AST_POLL_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    pollReq |=> !pollReq); // R2

  AST_ALARM_SET: assert property (@(posedge clk) disable iff (!rstN)
    (pollValid && pollCode == 2'd3) |=> overTempAlarm); // R6

  AST_ALARM_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (pollValid && pollCode != 2'd3) |=> !overTempAlarm); // R6

  AST_BANK_ROTATE: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && refGrant && !refAllBank) |=>
      (refBank == (($past(refBank) == BANK_W'(NUM_BANKS - 1)) ? '0 : $past(refBank) + BANK_W'(1)))); // R8

  AST_TARGET_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && !refUrgent && !refAllBank) |-> !bankBusy[refBank]); // R9

  AST_ALL_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && !refUrgent && refAllBank) |-> (bankBusy == '0)); // R10

  AST_ALLBANK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && refGrant && refAllBank) |=> $stable(refBank)); // R10

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    pendingCnt <= PEND_W'(MAX_POSTPONE)); // R11

  AST_URGENT_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    refUrgent |-> refReq); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (pendingCnt == '0) |-> (!refReq && !refUrgent)); // R12

endmodule

bind temp_refresh_sched temp_refresh_sched_chk #(
  .NUM_BANKS(NUM_BANKS), .MAX_POSTPONE(MAX_POSTPONE)
) chk_i (
  .clk(clk), .rstN(rstN), .pollReq(pollReq), .pollValid(pollValid),
  .pollCode(pollCode), .overTempAlarm(overTempAlarm), .bankBusy(bankBusy),
  .refReq(refReq), .refGrant(refGrant), .refAllBank(refAllBank),
  .refBank(refBank), .refUrgent(refUrgent), .pendingCnt(pendingCnt)
);

// File: tb/temp_refresh_sched_tb_top.sv
`timescale 1ns/1ps
module temp_refresh_sched_tb_top;

  localparam int NB   = 8;
  localparam int BASE = 64;
  localparam int POLL = 16;
  localparam int MAXP = 8;
  localparam int PB   = BASE / NB;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          perBankMode, pollReq, pollValid, overTempAlarm;
  logic [1:0]    pollCode;
  logic [NB-1:0] bankBusy;
  logic          refReq, refGrant, refAllBank, refUrgent;
  logic [2:0]    refBank;

  int cycle = 0;
  int nChecks = 0;
  int nFails = 0;
  int expBank = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  temp_refresh_sched #(
    .NUM_BANKS(NB), .BASE_INTERVAL(BASE), .POLL_PERIOD(POLL), .MAX_POSTPONE(MAXP)
  ) dut_i (
    .clk(clk), .rstN(rstN), .perBankMode(perBankMode), .pollReq(pollReq),
    .pollValid(pollValid), .pollCode(pollCode), .overTempAlarm(overTempAlarm),
    .bankBusy(bankBusy), .refReq(refReq), .refGrant(refGrant),
    .refAllBank(refAllBank), .refBank(refBank), .refUrgent(refUrgent)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkMin(input string tag, input int act, input int lo);
    nChecks++;
    if (act < lo) begin
      nFails++;
      $display("FAIL %s: actual %0d expected >= %0d", tag, act, lo);
    end
  endtask

  task automatic waitPulse(output int t);
    int guard = 0;
    @(negedge clk);
    while (!refReq && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    if (!refReq) check("R7 request timeout", 0, 1);
    t = cycle;
  endtask

  task automatic waitPoll(output int t);
    int guard = 0;
    @(negedge clk);
    while (!pollReq && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    if (!pollReq) check("R2 poll timeout", 0, 1);
    t = cycle;
  endtask

  // Per-bank pulse: check rotation and optional spacing
  task automatic bankPulse(inout int last, input int gapExp);
    int t;
    waitPulse(t);
    if (gapExp > 0) check("R4 per-bank interval", t - last, gapExp);
    check("R8 rotation bank", refBank, expBank);
    check("R8 per-bank flag", refAllBank, 0);
    expBank = (expBank + 1) % NB;
    last = t;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check("R7 watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    int t0, t1, p, q, tSet, n, bA;
    perBankMode = 1'b0; pollValid = 1'b1; pollCode = 2'd0;
    bankBusy = '0; refGrant = 1'b1;

    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 refReq in reset", refReq, 0);
    check("R1 refUrgent in reset", refUrgent, 0);
    check("R1 pollReq in reset", pollReq, 0);
    check("R1 alarm in reset", overTempAlarm, 0);
    check("R1 bank in reset", refBank, 0);
    check("R1 all-bank in reset", refAllBank, 1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 refReq after reset", refReq, 0);

    // R2 poll pulse width and period
    waitPoll(t0);
    @(negedge clk);
    check("R2 poll width", pollReq, 0);
    waitPoll(t1);
    check("R2 poll period", t1 - t0, POLL);

    // R4 all-bank nominal spacing
    waitPulse(p);
    check("R10 all-bank flag", refAllBank, 1);
    waitPulse(q);
    check("R4 all-bank 1x interval", q - p, BASE);

    // R5 code 2 mid-interval: old length once, then quarter
    repeat (3) @(negedge clk); pollCode = 2'd2;
    p = q; waitPulse(q); check("R5 old interval kept", q - p, BASE);
    p = q; waitPulse(q); check("R4 all-bank 4x interval", q - p, BASE / 4);

    // code 1: double rate
    repeat (3) @(negedge clk); pollCode = 2'd1;
    p = q; waitPulse(q); check("R5 old interval kept", q - p, BASE / 4);
    p = q; waitPulse(q); check("R4 all-bank 2x interval", q - p, BASE / 2);

    // R3 code without pollValid is ignored
    repeat (3) @(negedge clk); pollValid = 1'b0; pollCode = 2'd2;
    p = q; waitPulse(q); check("R3 ignored code", q - p, BASE / 2);
    p = q; waitPulse(q); check("R3 ignored code", q - p, BASE / 2);
    check("R3 ignored code alarm", overTempAlarm, 0);
    pollValid = 1'b1; pollCode = 2'd1;

    // R6 over-temperature code
    repeat (3) @(negedge clk); pollCode = 2'd3;
    @(negedge clk);
    check("R6 alarm raised", overTempAlarm, 1);
    p = q; waitPulse(q); check("R5 old interval kept", q - p, BASE / 2);
    p = q; waitPulse(q); check("R3 code 3 quarter interval", q - p, BASE / 4);

    // R5/R8 switch to per-bank at next reload
    repeat (3) @(negedge clk); pollCode = 2'd0; perBankMode = 1'b1;
    @(negedge clk);
    check("R6 alarm cleared", overTempAlarm, 0);
    p = q; waitPulse(q);
    check("R5 old interval kept", q - p, BASE / 4);
    check("R5 new mode at reload", refAllBank, 0);
    check("R10 pointer untouched in all-bank", refBank, 0);
    expBank = 1;
    for (int i = 0; i < 9; i++) bankPulse(q, PB);

    // per-bank quarter rate
    @(negedge clk); pollCode = 2'd2;
    bankPulse(q, PB);
    bankPulse(q, PB / 4);
    @(negedge clk); pollCode = 2'd0;
    bankPulse(q, PB / 4);
    bankPulse(q, PB / 4);
    bankPulse(q, PB);

    // R9 target bank busy: only the urgent path gets through
    @(negedge clk); bankBusy = NB'(1) << expBank; tSet = cycle;
    waitPulse(t0);
    check("R11 urgent overrides busy", refUrgent, 1);
    check("R9 blocked target kept", refBank, expBank);
    checkMin("R9 withheld while busy", t0 - tSet, 7 * PB);
    expBank = (expBank + 1) % NB;
    @(negedge clk); bankBusy = '0; #1;
    for (int i = 0; i < 20; i++) begin
      if (refReq) expBank = (expBank + 1) % NB;
      @(negedge clk); #1;
    end
    bankPulse(q, 0);

    // R9 other banks busy: no effect
    @(negedge clk); bankBusy = ~(NB'(1) << expBank);
    waitPulse(t1);
    check("R9 other banks ignored", refUrgent, 0);
    check("R9 other banks ignored bank", refBank, expBank);
    checkMin("R9 other banks ignored timing", PB + 1, t1 - q);
    expBank = (expBank + 1) % NB;
    @(negedge clk); bankBusy = '0;

    // R10 back to all-bank; any busy bank blocks
    perBankMode = 1'b0;
    waitPulse(p);
    check("R10 all-bank after switch", refAllBank, 1);
    bA = refBank;
    @(negedge clk); bankBusy = NB'(8'h10); tSet = cycle;
    waitPulse(q);
    check("R10 busy blocks all-bank", refUrgent, 1);
    checkMin("R10 withheld while busy", q - tSet, 7 * BASE);
    check("R10 bank unchanged", refBank, bA);
    @(negedge clk); bankBusy = '0;
    repeat (20) @(negedge clk);

    // R11 saturation with grant withheld
    refGrant = 1'b0;
    n = 0;
    while (!refUrgent && n < 2000) begin @(negedge clk); n++; end
    check("R11 urgent reached", refUrgent, 1);
    check("R7 request held without grant", refReq, 1);
    repeat (70) @(negedge clk);
    check("R11 urgent after extra interval", refUrgent, 1);
    refGrant = 1'b1; #1;
    n = 0;
    while (refReq && n < 20) begin n++; @(negedge clk); #1; end
    check("R11 saturated count drained", n, MAXP);
    check("R12 idle request", refReq, 0);
    check("R12 idle urgent", refUrgent, 0);

    finishRun();
  end

endmodule